// File: doc/BRIEF.md
# Compare Timer with Waveform Output

An 8-bit timer/counter with one compare channel and a waveform generator. Software drives it through a small register bus with four addresses. A free-running prescaler turns the core clock into count ticks. On each tick the counter steps through one of four counting sequences: plain up-count, up/down (phase-correct), clear on compare, and fast PWM. An equality comparator checks the counter against a compare value. The comparator sets a compare flag and moves an output pin according to a two-bit output mode.

The block has an overflow flag and a compare flag, each with its own enable. Each flag produces an interrupt request. The interrupt controller clears a flag by pulsing the matching acknowledge input, and software clears it by writing a one to the flag's bit. In both PWM sequences the compare value is double-buffered, so a new duty cycle starts only at the next counter top.

Top module: `cmp_timer`

## Requirements
- R1: Clock select values 0, 6 and 7 (control bits [2:0] at address 0) give no ticks, and the counter holds its value.
- R2: Clock select values 1, 2, 3, 4 and 5 tick the counter once every 1, 8, 32, 64 and 128 core cycles.
- R3: The counter (address 1) can be read and written at any time. A write sets the counter to the written value on that edge and overrides any step that a tick would cause on the same edge.
- R4: In sequence 00 (control bits [4:3]) the counter counts up and wraps from 0xFF to 0x00. The overflow flag is set on the edge of that wrap. The same rule sets the flag in sequences 10 and 11.
- R5: In sequence 10 the counter returns to 0x00 on the tick that leaves a value equal to the compare value, so the count period is compare+1 ticks.
- R6: In sequence 01 the counter rises to 0xFF and then falls to 0x00. The overflow flag is set on the tick that leaves 0x00.
- R7: The compare flag (address 3, bit 1) is set on the tick that leaves a counter value equal to the active compare value, one tick after the equality first shows.
- R8: Writing a 1 to flag bit 0 (overflow) or bit 1 (compare) at address 3 clears that flag, and writing 0 leaves it unchanged. Pulsing the matching acknowledge input also clears it.
- R9: Each request output is high exactly when its flag is set and its enable is 1. The overflow enable is address 3 bit 2 and the compare enable is bit 3.
- R10: In sequences 00 and 10 the output mode (control bits [6:5]) works as follows: 00 holds the pin low, and 01, 10 and 11 toggle, clear or set the output on a matching tick.
- R11: In sequence 11, output mode 10 sets the output on the tick at 0xFF and clears it on a matching tick, and the 0xFF set wins over the match. The output is high for compare+1 of every 256 ticks. Mode 11 inverts this, and modes 00 and 01 hold the pin low.
- R12: In sequence 01, output mode 10 clears the output on a match while rising and sets it on a match while falling. A compare value of 0x00 holds the output low and 0xFF holds it high, so it is high for 2*compare of every 510 ticks. Mode 11 inverts this.
- R13: In sequences 01 and 11, a write to the compare value (address 2) goes to a buffer, and the buffer is what reads back. The active value loads from the buffer on the tick at 0xFF. In sequences 00 and 10 a write takes effect at once.
- R14: After reset all registers, flags, requests and the output are 0. Address 0 reads back bits [6:0] of the control value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register address: 0 control, 1 counter, 2 compare, 3 flags/enables |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr, combinational |
| ack_ovf | input | 1 | Overflow interrupt acknowledge, clears the overflow flag |
| ack_cmp | input | 1 | Compare interrupt acknowledge, clears the compare flag |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmp | output | 1 | Compare interrupt request |
| wave_out | output | 1 | Waveform output pin |

## Verification
The bench builds the block with its default 8-bit counter. At that width a full fast-PWM period (256 ticks) and a full up/down period (510 ticks) fit in a short run, so the duty cycle can be summed over whole periods. The sum is checked against compare+1 or 2*compare at both extreme compare values and at values between them. With divide-by-1 ticks every counter step falls on a known edge, and the bench uses this to pin the exact edge of each flag, each override and each double-buffer load. It also measures the tick spacing for each of the five dividers directly, the largest being 128 cycles.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

  localparam int PRE_W = 7;

  typedef enum logic [1:0] {
    WM_NORMAL = 2'b00,
    WM_PHASE  = 2'b01,
    WM_CTC    = 2'b10,
    WM_FAST   = 2'b11
  } wmode_e;

  typedef enum logic [1:0] {
    OM_OFF    = 2'b00,
    OM_TOGGLE = 2'b01,
    OM_CLEAR  = 2'b10,
    OM_SET    = 2'b11
  } omode_e;

  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_COUNT = 2'd1;
  localparam logic [1:0] A_CMP   = 2'd2;
  localparam logic [1:0] A_FLAGS = 2'd3;

  // tick decision for a clock-select value and the free-running prescaler
  function automatic logic presc_hit(input logic [2:0] sel, input logic [PRE_W-1:0] pc);
    case (sel)
      3'd1:    return 1'b1;
      3'd2:    return &pc[2:0];
      3'd3:    return &pc[4:0];
      3'd4:    return &pc[5:0];
      3'd5:    return &pc[6:0];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic is_pwm(input wmode_e m);
    return (m == WM_PHASE) || (m == WM_FAST);
  endfunction

  // PWM level: the base value for non-inverting, its complement for inverting
  function automatic logic pwm_level(input omode_e om, input logic base);
    return (om == OM_SET) ? ~base : base;
  endfunction

  // pin is driven when the output mode connects it for this sequence
  function automatic logic pin_connected(input wmode_e m, input omode_e om);
    return is_pwm(m) ? om[1] : (om != OM_OFF);
  endfunction

endpackage

// File: rtl/cmp_timer_presc.sv
module cmp_timer_presc
  import cmp_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  output logic       tick
);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  assign tick = presc_hit(sel, pre_q);

  assert_stopped_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd0 || sel > 3'd5) |-> !tick);

endmodule

// File: rtl/cmp_timer_count.sv
module cmp_timer_count
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  wmode_e           mode,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             wr_cmp,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmp_buf,
  output logic             dir_up,
  output logic             at_max,
  output logic             at_bottom,
  output logic             match,
  output logic             ovf_evt,
  output logic             match_evt
);

  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_nx, act_q, buf_q;
  logic             dir_q, dir_nx;
  logic             pwm, load_evt;

  assign at_max    = (cnt_q == MAXV);
  assign at_bottom = (cnt_q == '0);
  assign match     = (cnt_q == act_q);
  assign pwm       = is_pwm(mode);
  assign load_evt  = pwm && tick && at_max;

  always_comb begin
    cnt_nx = cnt_q;
    dir_nx = dir_q;
    if (tick) begin
      unique case (mode)
        WM_PHASE: begin
          if (dir_q) begin
            if (at_max) begin dir_nx = 1'b0; cnt_nx = cnt_q - ONE; end
            else        cnt_nx = cnt_q + ONE;
          end else begin
            if (at_bottom) begin dir_nx = 1'b1; cnt_nx = cnt_q + ONE; end
            else           cnt_nx = cnt_q - ONE;
          end
        end
        WM_CTC:  cnt_nx = match ? '0 : cnt_q + ONE;
        default: cnt_nx = cnt_q + ONE;
      endcase
    end
    if (wr_cnt) begin
      cnt_nx = wr_val;
      dir_nx = dir_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else begin
      cnt_q <= cnt_nx;
      dir_q <= dir_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (wr_cmp) buf_q <= cmp_val;
      if (!pwm) begin
        if (wr_cmp) act_q <= cmp_val;
      end else if (load_evt) begin
        act_q <= buf_q;
      end
    end
  end

  assign ovf_evt   = tick && ((mode == WM_PHASE) ? (at_bottom && !dir_q) : at_max);
  assign match_evt = tick && match;
  assign cnt       = cnt_q;
  assign cmp_buf   = buf_q;
  assign dir_up    = dir_q;

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_cnt) |=> $stable(cnt_q));

  assert_write_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt_q == $past(wr_val)));

  assert_ctc_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt && mode == WM_CTC && match) |=> (cnt_q == '0));

  assert_pwm_buffer_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !load_evt) |=> $stable(act_q));

endmodule

// File: rtl/cmp_timer_wave.sv
module cmp_timer_wave
  import cmp_timer_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  wmode_e mode,
  input  omode_e com,
  input  logic   match,
  input  logic   at_max,
  input  logic   at_bottom,
  input  logic   dir_up,
  output logic   wave_out
);

  logic q, q_nx;

  always_comb begin
    q_nx = q;
    if (tick) begin
      if (!is_pwm(mode)) begin
        if (match) begin
          case (com)
            OM_TOGGLE: q_nx = ~q;
            OM_CLEAR:  q_nx = 1'b0;
            OM_SET:    q_nx = 1'b1;
            default:   q_nx = q;
          endcase
        end
      end else if (mode == WM_FAST) begin
        if (at_max)     q_nx = pwm_level(com, 1'b1);
        else if (match) q_nx = pwm_level(com, 1'b0);
      end else begin
        if (match) begin
          if (at_max)         q_nx = pwm_level(com, 1'b1);
          else if (at_bottom) q_nx = pwm_level(com, 1'b0);
          else                q_nx = pwm_level(com, !dir_up);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nx;
  end

  assign wave_out = pin_connected(mode, com) & q;

  assert_set_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && match && !is_pwm(mode) && com == OM_SET) |=> q);

  assert_fast_top_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_max && mode == WM_FAST && com == OM_CLEAR) |=> q);

endmodule

// File: rtl/cmp_timer_flag.sv
module cmp_timer_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic w1c,
  input  logic ack,
  input  logic en,
  output logic flag,
  output logic irq
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (set)        flag_q <= 1'b1;
    else if (w1c || ack) flag_q <= 1'b0;
  end

  assign flag = flag_q;
  assign irq  = flag_q & en;

  assert_flag_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set));

  assert_ack_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !set) |=> !flag_q);

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             ack_ovf,
  input  logic             ack_cmp,
  output logic             irq_ovf,
  output logic             irq_cmp,
  output logic             wave_out
);

  localparam int NFLAG = 2;

  logic [6:0]       ctrl_q;
  logic [NFLAG-1:0] ie_q;
  logic             tick;
  wmode_e           mode;
  omode_e           com;
  logic             wr_ctrl, wr_cnt, wr_cmp, wr_flags;
  logic [CNT_W-1:0] cnt, cmp_buf;
  logic             dir_up, at_max, at_bottom, match, ovf_evt, match_evt;
  logic [NFLAG-1:0] flag_set, flag_w1c, flag_ack, flag_q, flag_irq;

  assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
  assign wr_cnt   = bus_wr && (bus_addr == A_COUNT);
  assign wr_cmp   = bus_wr && (bus_addr == A_CMP);
  assign wr_flags = bus_wr && (bus_addr == A_FLAGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ie_q   <= '0;
    end else begin
      if (wr_ctrl)  ctrl_q <= bus_wdata[6:0];
      if (wr_flags) ie_q   <= bus_wdata[NFLAG+1:NFLAG];
    end
  end

  assign mode = wmode_e'(ctrl_q[4:3]);
  assign com  = omode_e'(ctrl_q[6:5]);

  cmp_timer_presc u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (ctrl_q[2:0]),
    .tick (tick)
  );

  cmp_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .mode     (mode),
    .wr_cnt   (wr_cnt),
    .wr_val   (bus_wdata),
    .wr_cmp   (wr_cmp),
    .cmp_val  (bus_wdata),
    .cnt      (cnt),
    .cmp_buf  (cmp_buf),
    .dir_up   (dir_up),
    .at_max   (at_max),
    .at_bottom(at_bottom),
    .match    (match),
    .ovf_evt  (ovf_evt),
    .match_evt(match_evt)
  );

  cmp_timer_wave u_wave (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .mode     (mode),
    .com      (com),
    .match    (match),
    .at_max   (at_max),
    .at_bottom(at_bottom),
    .dir_up   (dir_up),
    .wave_out (wave_out)
  );

  assign flag_set = {match_evt, ovf_evt};
  assign flag_ack = {ack_cmp, ack_ovf};

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign flag_w1c[i] = wr_flags && bus_wdata[i];
    cmp_timer_flag u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (flag_set[i]),
      .w1c  (flag_w1c[i]),
      .ack  (flag_ack[i]),
      .en   (ie_q[i]),
      .flag (flag_q[i]),
      .irq  (flag_irq[i])
    );
  end

  assign irq_ovf = flag_irq[0];
  assign irq_cmp = flag_irq[1];

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL:  bus_rdata[6:0] = ctrl_q;
      A_COUNT: bus_rdata = cnt;
      A_CMP:   bus_rdata = cmp_buf;
      default: bus_rdata[2*NFLAG-1:0] = {ie_q, flag_q};
    endcase
  end

  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ovf || irq_cmp) |-> (ie_q != '0));

endmodule

// File: tb/cmp_timer_tb.sv
module cmp_timer_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       ack_ovf, ack_cmp;
  logic       irq_ovf, irq_cmp, wave_out;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  cmp_timer #(.CNT_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ack_ovf(ack_ovf),
    .ack_cmp(ack_cmp), .irq_ovf(irq_ovf), .irq_cmp(irq_cmp), .wave_out(wave_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    bus_addr = a;
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] ctl(input int sel, input int mode, input int om);
    return 8'((om << 5) | (mode << 3) | sel);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int v, v0, v1, n, hi, bad, tog;
    logic prev;
    bus_addr = 0; bus_wr = 0; bus_wdata = 0; ack_ovf = 0; ack_cmp = 0;
    rst_n = 0;
    edges(3);
    rst_n = 1;
    edges(1);

    // R14 reset state
    rd(0, v); check("R14 ctrl reset", v, 0);
    rd(1, v); check("R14 count reset", v, 0);
    rd(2, v); check("R14 compare reset", v, 0);
    rd(3, v); check("R14 flags reset", v, 0);
    check("R14 outputs reset", int'({irq_ovf, irq_cmp, wave_out}), 0);

    // R1 stopped with select 0 and 6
    edges(40);
    rd(1, v); check("R1 sel0 hold", v, 0);
    wr(0, 8'd6); wr(1, 8'd77);
    rd(1, v); check("R3 write while stopped", v, 77);
    edges(40);
    rd(1, v); check("R1 sel6 hold", v, 77);
    rd(0, v); check("R14 ctrl readback", v, 6);

    // R2 tick spacing for each divider
    for (int s = 1; s <= 5; s++) begin
      int div;
      div = (s == 1) ? 1 : (s == 2) ? 8 : (s == 3) ? 32 : (s == 4) ? 64 : 128;
      wr(0, ctl(s, 0, 0));
      rd(1, v0);
      n = 0;
      do begin @(negedge clk); rd(1, v1); n++; end while (v1 == v0 && n < 300);
      v0 = v1; n = 0;
      do begin @(negedge clk); rd(1, v1); n++; end while (v1 == v0 && n < 300);
      check($sformatf("R2 spacing sel=%0d", s), n, div);
    end

    // R3 write overrides a tick on the same edge
    wr(0, ctl(1, 0, 0));
    wr(1, 8'h40);
    rd(1, v); check("R3 write beats tick", v, 8'h40);
    edges(3);
    rd(1, v); check("R3 count after write", v, 8'h43);

    // R4 wrap and overflow flag, R9 request
    wr(0, 8'd0); wr(1, 8'd250); wr(3, 8'h07); wr(0, ctl(1, 0, 0));
    rd(1, v); check("R4 start", v, 250);
    edges(5);
    rd(1, v); check("R4 at top", v, 255);
    rd(3, v); check("R4 flag before wrap", v & 1, 0);
    edges(1);
    rd(1, v); check("R4 wrapped", v, 0);
    rd(3, v); check("R4 flag on wrap", v & 1, 1);
    check("R9 irq_ovf", int'(irq_ovf), 1);

    // R7 compare flag one tick late, R9 request
    wr(0, 8'd0); wr(2, 8'd20); wr(1, 8'd18); wr(3, 8'h0B);
    check("R9 irq_ovf after disable", int'(irq_ovf), 0);
    wr(0, ctl(1, 0, 0));
    edges(2);
    rd(1, v); check("R7 count at match", v, 20);
    rd(3, v); check("R7 flag not yet", (v >> 1) & 1, 0);
    check("R9 irq_cmp low", int'(irq_cmp), 0);
    edges(1);
    rd(3, v); check("R7 flag set", (v >> 1) & 1, 1);
    check("R9 irq_cmp high", int'(irq_cmp), 1);

    // R8 acknowledge and write-one-to-clear
    wr(0, 8'd0);
    @(negedge clk); ack_cmp = 1'b1;
    @(negedge clk); ack_cmp = 1'b0;
    rd(3, v); check("R8 ack clears compare flag", (v >> 1) & 1, 0);
    check("R8 irq_cmp after ack", int'(irq_cmp), 0);
    wr(1, 8'd255); wr(0, ctl(1, 0, 0)); wr(0, 8'd0);
    wr(3, 8'h08);
    rd(3, v); check("R8 write zero keeps flag", v & 1, 1);
    wr(3, 8'h09);
    rd(3, v); check("R8 write one clears flag", v & 1, 0);
    check("R9 enable bit kept", (v >> 3) & 1, 1);

    // R5 clear-on-compare period and R10 toggle
    wr(0, ctl(0, 2, 1)); wr(2, 8'd9); wr(1, 8'd0); wr(0, ctl(1, 2, 1));
    bad = 0; tog = 0; prev = wave_out;
    for (int k = 1; k <= 100; k++) begin
      @(negedge clk);
      rd(1, v);
      if (v != k % 10) bad++;
      if (wave_out != prev) tog++;
      prev = wave_out;
    end
    check("R5 count sequence mismatches", bad, 0);
    check("R10 toggles in 100 ticks", tog, 10);
    wr(0, ctl(1, 2, 2)); edges(20);
    check("R10 clear on match", int'(wave_out), 0);
    wr(0, ctl(1, 2, 3)); edges(20);
    check("R10 set on match", int'(wave_out), 1);
    wr(0, ctl(1, 2, 0)); edges(2);
    check("R10 disconnected pin low", int'(wave_out), 0);

    // R11 fast PWM duty sweep
    for (int om = 2; om <= 3; om++) begin
      for (int i = 0; i < 5; i++) begin
        int k;
        k = (i == 0) ? 0 : (i == 1) ? 1 : (i == 2) ? 100 : (i == 3) ? 254 : 255;
        wr(0, ctl(1, 3, om)); wr(2, 8'(k));
        edges(600);
        hi = 0;
        repeat (256) begin @(negedge clk); hi += int'(wave_out); end
        check($sformatf("R11 fast duty om=%0d k=%0d", om, k), hi,
              (om == 2) ? k + 1 : 256 - (k + 1));
      end
    end
    wr(0, ctl(1, 3, 1)); edges(2);
    hi = 0;
    repeat (256) begin @(negedge clk); hi += int'(wave_out); end
    check("R11 fast mode 01 pin low", hi, 0);

    // R12 phase-correct duty sweep
    for (int i = 0; i < 5; i++) begin
      int k, om;
      k  = (i == 0) ? 0 : (i == 1) ? 1 : (i == 2) ? 128 : (i == 3) ? 255 : 128;
      om = (i == 4) ? 3 : 2;
      wr(0, ctl(1, 1, om)); wr(2, 8'(k));
      edges(1100);
      hi = 0;
      repeat (510) begin @(negedge clk); hi += int'(wave_out); end
      check($sformatf("R12 phase duty om=%0d k=%0d", om, k), hi,
            (om == 2) ? 2 * k : 510 - 2 * k);
    end

    // R6 overflow at bottom in up/down sequence
    wr(0, ctl(1, 1, 0));
    v0 = -1; n = 0;
    do begin @(negedge clk); rd(1, v1); n++;
      if (v1 == 3 && v0 == 4) break;
      v0 = v1;
    end while (n < 2000);
    wr(3, 8'h01);
    edges(1);
    rd(1, v); check("R6 reaches bottom", v, 0);
    rd(3, v); check("R6 no flag at bottom yet", v & 1, 0);
    edges(1);
    rd(1, v); check("R6 turns up", v, 1);
    rd(3, v); check("R6 flag leaving bottom", v & 1, 1);

    // R13 double buffer in fast PWM
    wr(0, ctl(1, 3, 2)); wr(2, 8'd200);
    edges(600);
    wr(1, 8'd250);
    edges(10);
    rd(1, v); check("R13 count after wrap", v, 4);
    check("R13 output high at start", int'(wave_out), 1);
    wr(2, 8'd20);
    rd(2, v); check("R13 buffer readback", v, 20);
    edges(24);
    rd(1, v); check("R13 count 30", v, 30);
    check("R13 old compare still active", int'(wave_out), 1);
    edges(256);
    rd(1, v); check("R13 count 30 next period", v, 30);
    check("R13 new compare active", int'(wave_out), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule